// File: doc/BRIEF.md
# Variable-Latency Carry Speculative Adder

This block adds two unsigned operands of `WIDTH` bits. The operands are split into `WIDTH/BLK` slices of `BLK` bits. All slices are added in the same cycle. Each slice above the lowest computes two results in advance: one for a carry-in of 0 and one for a carry-in of 1. The carry-in it actually uses is a guess. That guess is the carry produced by only the upper `PK` bit positions of the slice below, assuming no carry enters those positions from lower down. Each guess is then compared with the carry that the lower slice really produces under its own chosen carry-in.

When every guess is correct, the speculative sum is exact and is registered one cycle after the operand pair is accepted. When any guess is wrong, the pair is held for one extra cycle. During that cycle the real carries are rippled slice to slice, and the corrected sum is registered with an error flag. The cost in latency therefore depends on the operands.

Operands enter through a register stage under a valid/ready handshake. A new pair can be taken on every cycle except the one in which a mispredicted pair is waiting for correction.

Top module: `csa_spec_adder`

## Requirements
- R1: For every accepted pair, `out_sum` and `out_cout` together equal the exact `WIDTH+1`-bit unsigned sum `in_a + in_b`.
- R2: When no slice boundary mispredicts, `out_valid` rises with the result on the clock edge that follows the acceptance edge, and `out_err` is 0.
- R3: When at least one boundary mispredicts, the result appears one cycle later (two edges after acceptance) with `out_err` = 1.
- R4: A boundary's guess is the carry out of bit positions `BLK-PK` to `BLK-1` of the slice below, with a carry-in of 0 assumed at position `BLK-PK`. The lowest slice has a carry-in of 0. A misprediction is a boundary whose guess differs from the lower slice's carry under that slice's selected carry-in. Bits below `BLK-PK` never enter a guess.
- R5: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R6: `in_ready` is 0 only in the cycle where a registered pair has mispredicted and its correction has not yet happened. While that is true the held operands do not change. In all other cycles `in_ready` is 1, so error-free pairs stream at one per cycle.
- R7: `out_valid` is high for exactly one cycle per accepted pair, and results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The offered pair is taken at the next edge |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result registers hold a new result this cycle |
| out_sum | output | WIDTH | Sum bits |
| out_cout | output | 1 | Carry out of the top bit |
| out_err | output | 1 | The result needed the correction cycle |

## Verification
The assertions assume that `in_valid`, `in_a` and `in_b` carry known values in every cycle after reset. They also assume that a pair is counted as accepted only on an edge where `in_ready` was already high. The bench drives all inputs on the falling edge and reads `in_ready` before that edge. It holds the pair and `in_valid` steady until it has seen `in_ready` high, so every pair it logs is one that the design really took. The expected error flag comes from a separate bit-level model of the guessing rule in R4. Long carry chains such as all-ones plus one are included so that both latencies are exercised.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Results of one slice for both possible carry-ins.
    typedef struct packed {
        logic c_zero;
        logic c_one;
    } carry_pair_t;

    // Carry out of bit window [lo..hi] with zero carry entering at lo.
    function automatic logic window_carry(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input int unsigned lo,
                                          input int unsigned hi);
        logic c;
        c = 1'b0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i >= lo && i <= hi) begin
                c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/csa_block.sv
module csa_block #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]         a,
    input  logic [BW-1:0]         b,
    output logic [BW-1:0]         sum_c0,
    output logic [BW-1:0]         sum_c1,
    output csa_pkg::carry_pair_t  cout
);
    logic [BW:0] tot0;
    logic [BW:0] tot1;

    always_comb begin
        tot0 = {1'b0, a} + {1'b0, b};
        tot1 = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, 1'b1};
    end

    assign sum_c0      = tot0[BW-1:0];
    assign sum_c1      = tot1[BW-1:0];
    assign cout.c_zero = tot0[BW];
    assign cout.c_one  = tot1[BW];
endmodule

// File: rtl/csa_predict.sv
module csa_predict #(
    parameter int BW = 8,
    parameter int PK = 4
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    output logic          guess
);
    localparam int unsigned LO = BW - PK;
    localparam int unsigned HI = BW - 1;

    logic [63:0] a_ext;
    logic [63:0] b_ext;

    always_comb begin
        a_ext = '0;
        b_ext = '0;
        a_ext[BW-1:0] = a;
        b_ext[BW-1:0] = b;
        guess = csa_pkg::window_carry(a_ext, b_ext, LO, HI);
    end
endmodule

// File: rtl/csa_spec_adder.sv
module csa_spec_adder #(
    parameter int WIDTH = 32,
    parameter int BLK   = 8,
    parameter int PK    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout,
    output logic             out_err
);
    import csa_pkg::*;

    localparam int NB = WIDTH / BLK;

    initial begin
        if (WIDTH % BLK != 0 || NB < 2 || PK < 1 || PK > BLK || BLK > 64)
            $error("csa_spec_adder: bad parameter set");
    end

    // Operand stage
    logic [WIDTH-1:0] a_q, b_q;
    logic             vld_q;
    logic             fix_q;

    // Slice results
    logic [BLK-1:0] s0   [NB];
    logic [BLK-1:0] s1   [NB];
    carry_pair_t    cp   [NB];
    logic [NB-1:0]  guess;       // guess[j] : carry predicted out of slice j
    logic [NB-1:0]  spec_cin;
    logic [NB-1:0]  spec_cout;
    logic [NB-1:0]  err_vec;
    logic [NB:0]    true_c;
    logic [WIDTH-1:0] spec_sum, exact_sum;
    logic           any_err;
    logic           stall;

    for (genvar j = 0; j < NB; j++) begin : g_slice
        csa_block #(.BW(BLK)) u_blk (
            .a      (a_q[j*BLK +: BLK]),
            .b      (b_q[j*BLK +: BLK]),
            .sum_c0 (s0[j]),
            .sum_c1 (s1[j]),
            .cout   (cp[j])
        );

        if (j < NB - 1) begin : g_pred
            csa_predict #(.BW(BLK), .PK(PK)) u_pred (
                .a     (a_q[j*BLK +: BLK]),
                .b     (b_q[j*BLK +: BLK]),
                .guess (guess[j])
            );
        end else begin : g_top
            assign guess[j] = 1'b0;
        end

        if (j == 0) begin : g_low
            assign spec_cin[j] = 1'b0;
            assign err_vec[j]  = 1'b0;
        end else begin : g_up
            assign spec_cin[j] = guess[j-1];
            assign err_vec[j]  = guess[j-1] ^ spec_cout[j-1];
        end

        assign spec_cout[j]           = spec_cin[j] ? cp[j].c_one : cp[j].c_zero;
        assign spec_sum[j*BLK +: BLK] = spec_cin[j] ? s1[j] : s0[j];

        // Recovery chain: true carries rippled slice by slice
        assign true_c[j+1]             = true_c[j] ? cp[j].c_one : cp[j].c_zero;
        assign exact_sum[j*BLK +: BLK] = true_c[j] ? s1[j] : s0[j];

        // R1
        blk_inc_chk: assert property (@(posedge clk) disable iff (rst)
            {cp[j].c_one, s1[j]} == {cp[j].c_zero, s0[j]} + {{BLK{1'b0}}, 1'b1});
    end

    assign true_c[0] = 1'b0;
    assign any_err   = |err_vec;
    assign stall     = vld_q && !fix_q && any_err;
    assign in_ready  = !stall;

    // Operand register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            fix_q <= 1'b0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            fix_q <= stall;
            if (in_ready) begin
                vld_q <= in_valid;
                if (in_valid) begin
                    a_q <= in_a;
                    b_q <= in_b;
                end
            end
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_cout  <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= vld_q && !stall;
            if (vld_q && !stall) begin
                out_sum  <= fix_q ? exact_sum      : spec_sum;
                out_cout <= fix_q ? true_c[NB]     : spec_cout[NB-1];
                out_err  <= fix_q;
            end else begin
                out_err  <= 1'b0;
            end
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> fix_q && vld_q && $stable(a_q) && $stable(b_q) && in_ready);

    // R3
    fix_out_chk: assert property (@(posedge clk) disable iff (rst)
        fix_q |=> out_valid && out_err);

    // R1
    fix_exact_chk: assert property (@(posedge clk) disable iff (rst)
        fix_q |=> {out_cout, out_sum} == $past({1'b0, a_q}) + $past({1'b0, b_q}));

    // R2
    spec_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !fix_q && !any_err) |=>
            out_valid && !out_err &&
            {out_cout, out_sum} == $past({1'b0, a_q}) + $past({1'b0, b_q}));

    // R7
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_q |=> !out_valid);

    // R7
    err_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);
endmodule

// File: tb/tb_csa_spec_adder.sv
module tb_csa_spec_adder;
    localparam int W  = 16;
    localparam int X  = 4;
    localparam int K  = 2;
    localparam int NB = W / X;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_a, in_b;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;
    logic         out_err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [W+1:0] expq[$];   // {err, cout, sum}

    always #4 clk = ~clk;    // 125 MHz

    csa_spec_adder #(.WIDTH(W), .BLK(X), .PK(K)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
        .out_cout(out_cout), .out_err(out_err)
    );

    // Each { a, b } pair; expected values come from the models below.
    localparam logic [31:0] VEC [12] = '{
        {16'h0000, 16'h0000}, {16'hFFFF, 16'h0001}, {16'h1234, 16'h4321},
        {16'h00FF, 16'h0001}, {16'h8000, 16'h8000}, {16'h000B, 16'h0005},
        {16'h0007, 16'h0001}, {16'hFFFF, 16'hFFFF}, {16'h0F0F, 16'h00F1},
        {16'hA5A5, 16'h5A5A}, {16'h7FFF, 16'h0001}, {16'h3C3C, 16'h0404}
    };

    // R4 model: per-boundary guess from the upper K bits with zero carry-in
    function automatic logic model_err(logic [W-1:0] a, logic [W-1:0] b);
        int  cin = 0;
        logic e = 1'b0;
        for (int j = 0; j < NB - 1; j++) begin
            int ab  = (int'(a) >> (j*X)) & ((1 << X) - 1);
            int bb  = (int'(b) >> (j*X)) & ((1 << X) - 1);
            int tc  = ((ab + bb + cin) >> X) & 1;
            int ah  = ab >> (X - K);
            int bh  = bb >> (X - K);
            int prd = ((ah + bh) >> K) & 1;
            if (prd != tc) e = 1'b1;
            cin = prd;
        end
        return e;
    endfunction

    function automatic logic [W+1:0] model(logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return {model_err(a, b), s};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1 R7: every result checked in order against the logged pairs
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7 unexpected result", {14'd0, out_err, out_cout, out_sum}, 32'd0);
            end else begin
                logic [W+1:0] e;
                e = expq.pop_front();
                check({out_cout, out_sum} == e[W:0], "R1 sum",
                      {15'd0, out_cout, out_sum}, {15'd0, e[W:0]});
                check(out_err == e[W+1], "R4 err flag",
                      {31'd0, out_err}, {31'd0, e[W+1]});
            end
        end
    end

    // Offer one pair; returns on the falling edge after it was taken.
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        while (!in_ready) @(negedge clk);
        expq.push_back(model(a, b));
        @(negedge clk);
    endtask

    // Single pair from idle with latency and ready checks (R2 R3 R6 R7)
    task automatic single(input logic [W-1:0] a, input logic [W-1:0] b);
        int lat = 0;
        logic e;
        e = model_err(a, b);
        send(a, b);
        in_valid = 1'b0;
        check(in_ready == !e, "R6 ready while held", {31'd0, in_ready}, {31'd0, !e});
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (e ? 2 : 1), e ? "R3 latency" : "R2 latency", lat, e ? 2 : 1);
        @(negedge clk);
        check(!out_valid, "R7 single pulse", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        int nerr = 0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R5 during reset", {30'd0, out_valid, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R5 after reset", {30'd0, out_valid, in_ready}, 32'd1);

        // Table walk, one pair at a time
        for (int i = 0; i < 12; i++) begin
            single(VEC[i][31:16], VEC[i][15:0]);
        end

        // R4 directed: a guess wrong only because of bits below BLK-PK
        check(model_err(16'h000B, 16'h0005) == 1'b1, "R4 low bits ignored", 32'd0, 32'd1);
        // R4 directed: all-ones plus one mispredicts
        check(model_err(16'hFFFF, 16'h0001) == 1'b1, "R4 long chain", 32'd0, 32'd1);

        // R6 R7: back-to-back stream, random and long chains mixed
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (i % 7 == 0) ? W'(~a + W'(i % 3)) : W'($urandom);
            if (model_err(a, b)) nerr++;
            send(a, b);
        end
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R7 all results seen", expq.size(), 32'd0);
        check(nerr > 0, "R3 stream had mispredictions", nerr, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule